// File: doc/BRIEF.md
# Self-Refresh and Deep Power-Down Sequencer

This block controls the low-power states of a mobile DRAM device model. While the device sits in self-refresh, it issues refresh strobes to the memory arrays one at a time, and only to the arrays that a partial-array mask leaves enabled. The gap between strobes is scaled from a digital temperature code that an on-die sensor supplies, so a hotter die is refreshed more often. A separate deep power-down state turns off the internal supply and stops all refresh. On entry to deep power-down, the stored data is declared lost.

The sequencer is a four-state machine:

- `ST_IDLE`: normal operation.
- `ST_SELF_REF`: refresh strobes are generated.
- `ST_DEEP_PD`: the supply is off and data is lost.
- `ST_WAKE`: the supply is back on, and the block waits for the surrounding logic to confirm a full reinitialization.

The transitions are:

- IDLE→SELF_REF on `sr_enter`.
- SELF_REF→IDLE on `sr_exit`.
- IDLE→DEEP_PD on `dpd_enter`.
- DEEP_PD→WAKE on `dpd_exit`.
- WAKE→IDLE on `reinit_done`.

Any request that does not name a transition out of the current state is ignored.

Inside self-refresh, an interval timer counts down a length chosen from the temperature band. An array rotor then picks the next enabled array in ascending cyclic order after the array it served last.

Top module: `lp_refresh_seq`

## Requirements
- R1: After reset the block is in IDLE with `pwr_en`=1, `data_valid`=1 and `refresh_stb` all zero.
- R2: Bit i of `array_mask` enables array i. A strobe bit is set only for an array whose mask bit is 1 in that same cycle. No strobe is ever set outside self-refresh.
- R3: At most one strobe bit is set per cycle. Each strobe goes to the first enabled array after the last-served index in ascending cyclic order, and disabled arrays are skipped without costing an interval. After reset the lowest enabled index is served first. An all-zero mask produces no strobe and leaves the rotation position unchanged.
- R4: The first strobe comes in the L-th cycle of self-refresh, where L is the interval selected by the temperature code in the cycle in which `sr_enter` was accepted. Each later strobe comes L' cycles after the previous interval ended, with L' selected by the temperature code in the cycle in which that interval ended.
- R5: `temp_code` is unsigned degrees Celsius. With the defaults (base 16), the interval is 64 cycles for ≤45, 32 for 46..70, 16 for 71..85, and 8 above 85.
- R6: In IDLE, `sr_enter` leads to SELF_REF and `dpd_enter` leads to DEEP_PD, and `dpd_enter` wins if both are asserted together. In SELF_REF, `sr_exit` returns to IDLE.
- R7: From the first cycle in deep power-down, `pwr_en`=0, `data_valid`=0 and no strobes are issued.
- R8: `dpd_exit` leads from DEEP_PD to WAKE, where `pwr_en`=1 but `data_valid` stays 0. Only `reinit_done` in WAKE returns to IDLE and sets `data_valid` to 1.
- R9: Requests that are illegal in the current state have no effect. This covers `dpd_enter` and `dpd_exit` in SELF_REF, every request except `dpd_exit` in DEEP_PD, and every request except `reinit_done` in WAKE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| dpd_enter | input | 1 | Request to enter deep power-down |
| dpd_exit | input | 1 | Request to leave deep power-down |
| reinit_done | input | 1 | Reinitialization complete handshake |
| array_mask | input | N_ARRAYS | Per-array refresh enable |
| temp_code | input | TEMP_W | On-die temperature reading, °C |
| refresh_stb | output | N_ARRAYS | One-cycle refresh strobe per array |
| pwr_en | output | 1 | Internal supply enable |
| data_valid | output | 1 | Stored contents are valid |

## Verification
A wrong state register shows at once. A stray DEEP_PD drops `pwr_en` in the next cycle, and a stray WAKE or DEEP_PD clears `data_valid`. A missing SELF_REF state shows as an absent strobe within at most one interval, which is 64 cycles at default parameters. A wrong interval count or temperature band makes a strobe land early or late in a cycle that the bench predicts exactly. A wrong rotation pointer shows on the very next strobe as a wrong bit position. The bench therefore compares every output in every cycle against its own model, under directed band, mask and illegal-request sequences and under seeded random traffic.

// File: rtl/lp_seq_pkg.sv
`timescale 1ns/1ps
package lp_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SELF_REF = 2'd1,
        ST_DEEP_PD  = 2'd2,
        ST_WAKE     = 2'd3
    } lp_state_e;

    typedef enum logic [1:0] {
        BAND_COOL = 2'd0,
        BAND_MILD = 2'd1,
        BAND_HOT  = 2'd2,
        BAND_CRIT = 2'd3
    } temp_band_e;
endpackage

// File: rtl/lp_mode_fsm.sv
`timescale 1ns/1ps
module lp_mode_fsm
    import lp_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sr_enter,
    input  logic      sr_exit,
    input  logic      dpd_enter,
    input  logic      dpd_exit,
    input  logic      reinit_done,
    output lp_state_e state,
    output logic      pwr_en,
    output logic      data_valid,
    output logic      in_self_ref
);
    lp_state_e state_q, state_d;
    logic      valid_q;

    // next-state decode; requests not named per state are dropped
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dpd_enter)     state_d = ST_DEEP_PD;
                else if (sr_enter) state_d = ST_SELF_REF;
            end
            ST_SELF_REF: if (sr_exit)     state_d = ST_IDLE;
            ST_DEEP_PD:  if (dpd_exit)    state_d = ST_WAKE;
            ST_WAKE:     if (reinit_done) state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // contents validity: lost on power-down entry, restored by reinit only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_q <= 1'b1;
        else if (state_q == ST_IDLE && state_d == ST_DEEP_PD)
            valid_q <= 1'b0;
        else if (state_q == ST_WAKE && state_d == ST_IDLE)
            valid_q <= 1'b1;
    end

    // outputs
    always_comb begin
        state       = state_q;
        pwr_en      = (state_q != ST_DEEP_PD);
        in_self_ref = (state_q == ST_SELF_REF);
        data_valid  = valid_q;
    end

    AST_SR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SELF_REF && !sr_exit) |=> (state_q == ST_SELF_REF)); // R9
    AST_DPD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && dpd_enter) |=> (state_q == ST_DEEP_PD)); // R6
    AST_DPD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEEP_PD && !dpd_exit) |=> (state_q == ST_DEEP_PD)); // R9
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> ($past(state_q) == ST_WAKE)); // R8
endmodule

// File: rtl/lp_interval_timer.sv
`timescale 1ns/1ps
module lp_interval_timer
    import lp_seq_pkg::*;
#(
    parameter int BASE_TICKS = 16,
    parameter int TEMP_W     = 8,
    parameter int COOL_MAX   = 45,
    parameter int MILD_MAX   = 70,
    parameter int HOT_MAX    = 85
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              tick
);
    localparam int MAX_LEN = BASE_TICKS * 4;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic [CW-1:0] cnt_q;
    temp_band_e    band;
    logic [CW-1:0] reload;

    always_comb begin
        if (temp_code <= TEMP_W'(COOL_MAX))      band = BAND_COOL;
        else if (temp_code <= TEMP_W'(MILD_MAX)) band = BAND_MILD;
        else if (temp_code <= TEMP_W'(HOT_MAX))  band = BAND_HOT;
        else                                     band = BAND_CRIT;
    end

    always_comb begin
        unique case (band)
            BAND_COOL: reload = CW'(BASE_TICKS * 4 - 1);
            BAND_MILD: reload = CW'(BASE_TICKS * 2 - 1);
            BAND_HOT:  reload = CW'(BASE_TICKS - 1);
            BAND_CRIT: reload = CW'(BASE_TICKS / 2 - 1);
            default:   reload = CW'(BASE_TICKS - 1);
        endcase
    end

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CW'(BASE_TICKS - 1);
        else if (!run || tick)
            cnt_q <= reload;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    // independent gap counter for the window check
    logic [CW:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             gap_q <= '0;
        else if (!run || tick)  gap_q <= '0;
        else                    gap_q <= gap_q + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < (CW+1)'(MAX_LEN)); // R4
    AST_TICK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run); // R2
endmodule

// File: rtl/lp_array_rotor.sv
`timescale 1ns/1ps
module lp_array_rotor #(
    parameter int N_ARRAYS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [N_ARRAYS-1:0] mask,
    output logic [N_ARRAYS-1:0] stb
);
    localparam int IW = (N_ARRAYS > 1) ? $clog2(N_ARRAYS) : 1;

    logic [IW-1:0] last_q;
    logic [IW-1:0] sel;
    logic          found;

    // first enabled array after the last served one, cyclically
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 1; i <= N_ARRAYS; i++) begin
            int idx;
            idx = (int'(last_q) + i) % N_ARRAYS;
            if (!found && mask[idx]) begin
                sel   = IW'(idx);
                found = 1'b1;
            end
        end
    end

    for (genvar k = 0; k < N_ARRAYS; k++) begin : g_stb
        assign stb[k] = tick && found && (sel == IW'(k));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             last_q <= IW'(N_ARRAYS - 1);
        else if (tick && found) last_q <= sel;
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb)); // R3
    AST_STB_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (stb & ~mask) == '0); // R2
    AST_EMPTY_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> $stable(last_q)); // R3
endmodule

// File: rtl/lp_refresh_seq.sv
`timescale 1ns/1ps
module lp_refresh_seq
    import lp_seq_pkg::*;
#(
    parameter int N_ARRAYS   = 4,
    parameter int TEMP_W     = 8,
    parameter int BASE_TICKS = 16,
    parameter int COOL_MAX   = 45,
    parameter int MILD_MAX   = 70,
    parameter int HOT_MAX    = 85
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sr_enter,
    input  logic                sr_exit,
    input  logic                dpd_enter,
    input  logic                dpd_exit,
    input  logic                reinit_done,
    input  logic [N_ARRAYS-1:0] array_mask,
    input  logic [TEMP_W-1:0]   temp_code,
    output logic [N_ARRAYS-1:0] refresh_stb,
    output logic                pwr_en,
    output logic                data_valid
);
    lp_state_e state;
    logic      in_self_ref;
    logic      tick;

    lp_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_enter    (sr_enter),
        .sr_exit     (sr_exit),
        .dpd_enter   (dpd_enter),
        .dpd_exit    (dpd_exit),
        .reinit_done (reinit_done),
        .state       (state),
        .pwr_en      (pwr_en),
        .data_valid  (data_valid),
        .in_self_ref (in_self_ref)
    );

    lp_interval_timer #(
        .BASE_TICKS (BASE_TICKS),
        .TEMP_W     (TEMP_W),
        .COOL_MAX   (COOL_MAX),
        .MILD_MAX   (MILD_MAX),
        .HOT_MAX    (HOT_MAX)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (in_self_ref),
        .temp_code (temp_code),
        .tick      (tick)
    );

    lp_array_rotor #(
        .N_ARRAYS (N_ARRAYS)
    ) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .mask  (array_mask),
        .stb   (refresh_stb)
    );

    AST_DPD_SUPPLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP_PD) |-> (!pwr_en && !data_valid && refresh_stb == '0)); // R7
    AST_NO_STB_OUTSIDE_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SELF_REF) |-> (refresh_stb == '0)); // R2
    AST_WAKE_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP_PD) |=> (state != ST_IDLE)); // R8
endmodule

// File: tb/lp_refresh_seq_bench.sv
`timescale 1ns/1ps
module lp_refresh_seq_bench;
    localparam int N    = 4;
    localparam int TW   = 8;
    localparam int BASE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sr_enter = 0, sr_exit = 0, dpd_enter = 0, dpd_exit = 0, reinit_done = 0;
    logic [N-1:0]  array_mask = '0;
    logic [TW-1:0] temp_code = '0;
    logic [N-1:0]  refresh_stb;
    logic          pwr_en, data_valid;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    done   = 0;
    bit    cmp_on = 0;
    string tag    = "R1";

    always #2.5 clk = ~clk;

    lp_refresh_seq #(.N_ARRAYS(N), .TEMP_W(TW), .BASE_TICKS(BASE)) u_lp_refresh_seq (
        .clk(clk), .rst_n(rst_n), .sr_enter(sr_enter), .sr_exit(sr_exit),
        .dpd_enter(dpd_enter), .dpd_exit(dpd_exit), .reinit_done(reinit_done),
        .array_mask(array_mask), .temp_code(temp_code),
        .refresh_stb(refresh_stb), .pwr_en(pwr_en), .data_valid(data_valid)
    );

    // ---- expected-value functions from the requirements ----
    function automatic int len_of(input logic [TW-1:0] t);
        if (t <= 45)      return BASE * 4;
        else if (t <= 70) return BASE * 2;
        else if (t <= 85) return BASE;
        else              return BASE / 2;
    endfunction

    function automatic int next_of(input int last, input logic [N-1:0] m);
        for (int i = 1; i <= N; i++)
            if (m[(last + i) % N]) return (last + i) % N;
        return -1;
    endfunction

    // model state: 0 idle, 1 self-refresh, 2 deep power-down, 3 wake
    int m_st, m_len, m_age, m_last;
    bit m_valid;

    function automatic logic [N-1:0] exp_stb();
        int n;
        n = next_of(m_last, array_mask);
        if (m_st == 1 && m_age == m_len - 1 && n >= 0) return N'(1) << n;
        return '0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_valid <= 1; m_last <= N - 1; m_len <= 1; m_age <= 0;
        end else begin
            if (m_st != 1) begin
                m_len <= len_of(temp_code); m_age <= 0;
            end else if (m_age == m_len - 1) begin
                m_len <= len_of(temp_code); m_age <= 0;
                if (next_of(m_last, array_mask) >= 0) m_last <= next_of(m_last, array_mask);
            end else m_age <= m_age + 1;
            case (m_st)
                0: if (dpd_enter) begin m_st <= 2; m_valid <= 0; end
                   else if (sr_enter) m_st <= 1;
                1: if (sr_exit) m_st <= 0;
                2: if (dpd_exit) m_st <= 3;
                default: if (reinit_done) begin m_st <= 0; m_valid <= 1; end
            endcase
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) if (cmp_on && rst_n) begin
        chk(tag, "refresh_stb", 32'(refresh_stb), 32'(exp_stb()));
        chk(tag, "pwr_en", 32'(pwr_en), 32'(m_st != 2));
        chk(tag, "data_valid", 32'(data_valid), 32'(m_valid));
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic clr_req();
        sr_enter = 0; sr_exit = 0; dpd_enter = 0; dpd_exit = 0; reinit_done = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog: actual=%0d expected<150000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1", "stb after reset", 32'(refresh_stb), 0);
        chk("R1", "pwr_en after reset", 32'(pwr_en), 1);
        chk("R1", "data_valid after reset", 32'(data_valid), 1);
        cmp_on = 1;

        // R4 cool band, sparse mask: first strobe lands on array 1 after 64 cycles
        tag = "R4"; temp_code = 8'd30; array_mask = 4'b1010;
        sr_enter = 1; step(1); clr_req();
        step(BASE * 4 - 2);
        chk("R4", "no strobe before first interval", 32'(refresh_stb), 0);
        step(1);
        chk("R3", "first strobe to lowest enabled array", 32'(refresh_stb), 32'h2);
        step(BASE * 4 * 2);
        // R5 band sweep
        tag = "R5";
        temp_code = 8'd46;  step(BASE * 6);
        temp_code = 8'd70;  step(BASE * 4);
        temp_code = 8'd71;  step(BASE * 3);
        temp_code = 8'd85;  step(BASE * 2);
        temp_code = 8'd86;  step(BASE * 2);
        temp_code = 8'd255; step(BASE * 2);
        // R3 empty mask then full mask rotation
        tag = "R3"; array_mask = 4'b0000; step(BASE * 2);
        array_mask = 4'b1111; step(BASE * 3);
        array_mask = 4'b0001; step(BASE * 2);
        // R9 illegal power-down requests inside self-refresh
        tag = "R9"; dpd_enter = 1; step(1); clr_req();
        dpd_exit = 1; reinit_done = 1; sr_enter = 1; step(1); clr_req();
        step(BASE * 2);
        // R6 exit, then simultaneous enter requests
        tag = "R6"; sr_exit = 1; step(1); clr_req(); step(BASE * 5);
        chk("R2", "no strobe in idle", 32'(refresh_stb), 0);
        sr_enter = 1; dpd_enter = 1; step(1); clr_req();
        chk("R6", "power-down wins over self-refresh", 32'(pwr_en), 0);
        // R7 deep power-down
        tag = "R7";
        chk("R7", "data lost in power-down", 32'(data_valid), 0);
        // R9 illegal requests in power-down
        tag = "R9"; sr_enter = 1; sr_exit = 1; reinit_done = 1; dpd_enter = 1; step(1); clr_req();
        step(BASE * 5);
        chk("R9", "requests ignored in power-down", 32'(pwr_en), 0);
        // R8 wake path
        tag = "R8"; dpd_exit = 1; step(1); clr_req();
        chk("R8", "supply back in wake", 32'(pwr_en), 1);
        chk("R8", "data still invalid in wake", 32'(data_valid), 0);
        tag = "R9"; sr_enter = 1; dpd_enter = 1; dpd_exit = 1; step(1); clr_req();
        step(BASE * 5);
        chk("R9", "no strobe in wake", 32'(refresh_stb), 0);
        chk("R9", "still invalid after illegal wake requests", 32'(data_valid), 0);
        tag = "R8"; reinit_done = 1; step(1); clr_req();
        chk("R8", "reinit restores valid", 32'(data_valid), 1);

        // constrained random traffic
        tag = "R2";
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 48);
            clr_req();
            case (r)
                0: sr_enter = 1;
                1: sr_exit = 1;
                2: dpd_enter = 1;
                3: dpd_exit = 1;
                4, 5: reinit_done = 1;
                6: begin sr_enter = 1; dpd_enter = 1; end
                default: ;
            endcase
            if ($urandom % 40 == 0) temp_code = TW'($urandom % 128);
            if ($urandom % 60 == 0) array_mask = N'($urandom);
            step(1);
        end
        clr_req();
        step(2);
        finish_run();
    end
endmodule